// File: doc/BRIEF.md
# Opcode stream decoder

This block turns a stream of big-endian 16-bit instruction words into one decoded record per instruction. The first word of each instruction is classified by its top four bits into an operation group. The classification also fixes how many immediate or displacement extension words follow: none, one or two. The block takes in exactly that many further words and then presents a single record. The record carries an operation code, operand size, condition, register and mode fields, a 32-bit immediate or displacement value, the total length in bytes, and an illegal flag.

Input words and output records each use a valid/ready handshake. While a record waits to be consumed, no further input word is taken. The effective-address fields of the first word are passed on as the record's side port to a separate operand decoder, which fetches its own extension words: the low register field, the mode field and the size. The instruction length counted here covers the opcode word and the immediate or displacement words only. A two-bit generation input enables the later forms.

Top module: `opcode_stream_decoder`

## Requirements
- R1: Bits 15:12 of the first word pick the group, and `rec_op` takes one of these codes: 0 illegal; 1..6 immediate OR, AND, SUB, ADD, XOR, CMP; 7..9 OR/AND/XOR to condition byte; 10..12 OR/AND/XOR to status word; 13 bit op; 14 move; 15 other miscellaneous; 16..23 the eight words 4E70..4E77; 24 trap; 25 link; 26 unlink; 27 quick add; 28 quick sub; 29 set-on-condition; 30 decrement-and-branch; 31 branch always; 32 branch to subroutine; 33 conditional branch; 34 quick move; 35 divide/OR; 36 subtract; 37 compare/XOR; 38 multiply/AND; 39 add; 40 shift. Groups 1, 2 and 3 are moves with `rec_size` 00, 10 and 01 respectively.
- R2: A first word in group A or F, or any other undefined encoding, produces a record with `rec_illegal`=1, `rec_op`=0, `rec_imm`=0 and `rec_len`=2, and no extension word is taken.
- R3: After reset `out_valid` is 0 and `in_ready` is 1. While `out_valid` is 1, `in_ready` is 0, and the record stays unchanged until it is taken with `out_ready`.
- R4: In the branch group, a nonzero low byte is a sign-extended displacement (length 2). A low byte of 00 takes one sign-extended word (length 4). A low byte of FF with `gen`>=2 takes two words, the first of which is the upper half (length 6). With `gen`<2, FF is the displacement -1.
- R5: A branch condition of 0000 gives code 31 and 0001 gives code 32. Any other condition gives code 33. `rec_cond` always carries bits 11:8.
- R6: Group 0 immediates with bits 11:8 equal to 0, 2, 4, 6, A or C take one word for size 00 or 01 and two words for size 10. The byte form keeps only the low 8 bits, and the value is zero-extended. Size 11 or any other operation value is illegal.
- R7: In group 0, low six bits of 111100 select the condition-byte form (size 00, value of the low 8 bits) or the status-word form (size 01, value of the whole word), for bits 11:8 equal to 0, 2 or A. Each form takes one word. Any other combination is illegal.
- R8: Quick add/sub puts bits 11:9 into `rec_imm`, with 0 read as 8. Bit 8 selects subtract. With size 11, mode 001 is decrement-and-branch with one sign-extended word, and any other mode is set-on-condition.
- R9: Quick move with bit 8 set is illegal. Otherwise `rec_rx` is bits 11:9 and `rec_imm` is bits 7:0 sign-extended.
- R10: Words 4E70..4E77 give codes 16..23 in order. Code 18 takes one zero-extended word. Code 20 takes one sign-extended word and is illegal when `gen` is 0. Words 4E78..4E7F and unlisted group 4 words give code 15.
- R11: 4E4x is trap with `rec_imm`=x. 4E5x with bit 3 clear is link with one sign-extended word, and with bit 3 set it is unlink with length 2.
- R12: `rec_len` is 2 plus 2 per extension word taken. The record becomes valid in the cycle after the last word is accepted, and input gaps (`in_valid` low) consume nothing. `rec_rx`, `rec_ry`, `rec_ea_mode` are bits 11:9, 2:0, 5:3 of the first word.
- R13: Group 0 with bit 8 set is a bit op of length 2. Bits 11:8 equal to 1000 (bit 8 clear) is a bit op that takes one word, zero-extended. Groups 8, 9, B, C, D, E give codes 35..40 with length 2 and `rec_size` equal to bits 7:6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen | input | 2 | Processor generation: 0 base, 1 adds return-and-deallocate, 2 or more adds long branch |
| in_valid | input | 1 | Instruction word valid |
| in_word | input | 16 | Instruction word |
| in_ready | output | 1 | Word accepted when high with in_valid |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Record consumed when high with out_valid |
| rec_op | output | 6 | Operation code (R1) |
| rec_size | output | 2 | Size: 00 byte, 01 word, 10 long, 11 none |
| rec_cond | output | 4 | Bits 11:8 of the first word |
| rec_rx | output | 3 | Bits 11:9 of the first word |
| rec_ry | output | 3 | Bits 2:0, to the operand decoder |
| rec_ea_mode | output | 3 | Bits 5:3, to the operand decoder |
| rec_imm | output | 32 | Immediate or displacement |
| rec_len | output | 4 | Length in bytes |
| rec_illegal | output | 1 | Undefined encoding |

## Verification
The bench targets the branch escape bytes 00 and FF on both sides of the generation gate. A decoder that got these wrong would take too few or too many words and fall out of step with the stream for every later instruction. It also covers the byte immediate that must drop the upper half of its word, the zero-means-eight quick data, and the generation-gated return-and-deallocate. Illegal group 0 corners are checked too: size 11, an unused operation value, and a condition-byte pattern with the wrong size. These must yield a two-byte illegal record rather than swallow the next opcode. Holding `out_ready` low while garbage is offered on the input shows whether a full decoder wrongly takes a word.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  localparam int WORD_W  = 16;
  localparam int IMM_W   = 32;
  localparam int MAX_EXT = 2;
  localparam int CNT_W   = $clog2(MAX_EXT + 1);
  localparam int LEN_W   = 4;
  localparam int OP_W    = 6;

  typedef enum logic [OP_W-1:0] {
    OP_ILL   = 6'd0,  OP_ORI   = 6'd1,  OP_ANDI  = 6'd2,  OP_SUBI  = 6'd3,
    OP_ADDI  = 6'd4,  OP_EORI  = 6'd5,  OP_CMPI  = 6'd6,  OP_ORCB  = 6'd7,
    OP_ANDCB = 6'd8,  OP_EORCB = 6'd9,  OP_ORSW  = 6'd10, OP_ANDSW = 6'd11,
    OP_EORSW = 6'd12, OP_BIT   = 6'd13, OP_MOVE  = 6'd14, OP_MISC  = 6'd15,
    OP_RST   = 6'd16, OP_NOP   = 6'd17, OP_STOP  = 6'd18, OP_RTE   = 6'd19,
    OP_RTD   = 6'd20, OP_RTS   = 6'd21, OP_TRPV  = 6'd22, OP_RTR   = 6'd23,
    OP_TRAP  = 6'd24, OP_LINK  = 6'd25, OP_UNLK  = 6'd26, OP_ADDQ  = 6'd27,
    OP_SUBQ  = 6'd28, OP_SCC   = 6'd29, OP_DBCC  = 6'd30, OP_BRA   = 6'd31,
    OP_BSR   = 6'd32, OP_BCC   = 6'd33, OP_MOVQ  = 6'd34, OP_DIVOR = 6'd35,
    OP_SUB   = 6'd36, OP_CMPEO = 6'd37, OP_MULAN = 6'd38, OP_ADD   = 6'd39,
    OP_SHIFT = 6'd40
  } op_e;

  typedef enum logic [2:0] {
    IK_NONE, IK_BYTE, IK_UWORD, IK_SWORD, IK_LONG
  } imm_kind_e;

  typedef enum logic [1:0] {ST_OP, ST_EXT, ST_OUT} dec_state_e;
endpackage

// File: rtl/opdec_classify.sv
module opdec_classify
  import opdec_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        gen,
  output op_e               op,
  output logic              illegal,
  output logic [CNT_W-1:0]  n_ext,
  output imm_kind_e         kind,
  output logic [IMM_W-1:0]  imm0,
  output logic [1:0]        size
);
  logic bad;
  logic [2:0] qdata;

  assign qdata = word[11:9];

  always_comb begin
    op    = OP_ILL;
    bad   = 1'b0;
    n_ext = '0;
    kind  = IK_NONE;
    imm0  = '0;
    size  = word[7:6];
    unique case (word[15:12])
      4'h0: begin
        if (word[5:0] == 6'b111100) begin
          if (word[7] == 1'b0) begin
            n_ext = CNT_W'(1);
            kind  = word[6] ? IK_UWORD : IK_BYTE;
            unique case (word[11:8])
              4'h0:    op = word[6] ? OP_ORSW  : OP_ORCB;
              4'h2:    op = word[6] ? OP_ANDSW : OP_ANDCB;
              4'hA:    op = word[6] ? OP_EORSW : OP_EORCB;
              default: bad = 1'b1;
            endcase
          end else begin
            bad = 1'b1;
          end
        end else if (word[8]) begin
          op = OP_BIT;
        end else if (word[11:8] == 4'h8) begin
          op    = OP_BIT;
          n_ext = CNT_W'(1);
          kind  = IK_UWORD;
        end else if (word[7:6] != 2'b11) begin
          n_ext = (word[7:6] == 2'b10) ? CNT_W'(2) : CNT_W'(1);
          kind  = (word[7:6] == 2'b10) ? IK_LONG :
                  (word[7:6] == 2'b01) ? IK_UWORD : IK_BYTE;
          unique case (word[11:8])
            4'h0:    op = OP_ORI;
            4'h2:    op = OP_ANDI;
            4'h4:    op = OP_SUBI;
            4'h6:    op = OP_ADDI;
            4'hA:    op = OP_EORI;
            4'hC:    op = OP_CMPI;
            default: bad = 1'b1;
          endcase
        end else begin
          bad = 1'b1;
        end
      end
      4'h1: begin op = OP_MOVE; size = 2'b00; end
      4'h2: begin op = OP_MOVE; size = 2'b10; end
      4'h3: begin op = OP_MOVE; size = 2'b01; end
      4'h4: begin
        if (word[11:4] == 8'hE7) begin
          if (word[3]) begin
            op = OP_MISC;
          end else begin
            op = op_e'(6'd16 + {3'b000, word[2:0]});
            if (word[2:0] == 3'd2) begin
              n_ext = CNT_W'(1);
              kind  = IK_UWORD;
            end else if (word[2:0] == 3'd4) begin
              n_ext = CNT_W'(1);
              kind  = IK_SWORD;
              bad   = (gen == 2'd0);
            end
          end
        end else if (word[11:4] == 8'hE4) begin
          op   = OP_TRAP;
          imm0 = IMM_W'(word[3:0]);
        end else if (word[11:4] == 8'hE5) begin
          if (word[3]) begin
            op = OP_UNLK;
          end else begin
            op    = OP_LINK;
            n_ext = CNT_W'(1);
            kind  = IK_SWORD;
          end
        end else begin
          op = OP_MISC;
        end
      end
      4'h5: begin
        if (word[7:6] != 2'b11) begin
          op   = word[8] ? OP_SUBQ : OP_ADDQ;
          imm0 = (qdata == 3'd0) ? IMM_W'(8) : IMM_W'(qdata);
        end else if (word[5:3] == 3'b001) begin
          op    = OP_DBCC;
          n_ext = CNT_W'(1);
          kind  = IK_SWORD;
        end else begin
          op = OP_SCC;
        end
      end
      4'h6: begin
        op = (word[11:8] == 4'h0) ? OP_BRA :
             (word[11:8] == 4'h1) ? OP_BSR : OP_BCC;
        if (word[7:0] == 8'h00) begin
          n_ext = CNT_W'(1);
          kind  = IK_SWORD;
        end else if (word[7:0] == 8'hFF && gen >= 2'd2) begin
          n_ext = CNT_W'(2);
          kind  = IK_LONG;
        end else begin
          imm0 = {{(IMM_W-8){word[7]}}, word[7:0]};
        end
      end
      4'h7: begin
        if (word[8]) begin
          bad = 1'b1;
        end else begin
          op   = OP_MOVQ;
          imm0 = {{(IMM_W-8){word[7]}}, word[7:0]};
        end
      end
      4'h8: op = OP_DIVOR;
      4'h9: op = OP_SUB;
      4'hB: op = OP_CMPEO;
      4'hC: op = OP_MULAN;
      4'hD: op = OP_ADD;
      4'hE: op = OP_SHIFT;
      default: bad = 1'b1;
    endcase
    if (bad) begin
      op    = OP_ILL;
      n_ext = '0;
      kind  = IK_NONE;
      imm0  = '0;
    end
    illegal = bad;
  end
endmodule

// File: rtl/opdec_imm_shape.sv
module opdec_imm_shape
  import opdec_pkg::*;
(
  input  imm_kind_e         kind,
  input  logic [WORD_W-1:0] hi,
  input  logic [WORD_W-1:0] lo,
  input  logic [IMM_W-1:0]  imm0,
  output logic [IMM_W-1:0]  imm
);
  always_comb begin
    unique case (kind)
      IK_BYTE:  imm = {{(IMM_W-8){1'b0}}, lo[7:0]};
      IK_UWORD: imm = {{(IMM_W-WORD_W){1'b0}}, lo};
      IK_SWORD: imm = {{(IMM_W-WORD_W){lo[WORD_W-1]}}, lo};
      IK_LONG:  imm = {hi, lo};
      default:  imm = imm0;
    endcase
  end
endmodule

// File: rtl/opcode_stream_decoder.sv
module opcode_stream_decoder
  import opdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        gen,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OP_W-1:0]   rec_op,
  output logic [1:0]        rec_size,
  output logic [3:0]        rec_cond,
  output logic [2:0]        rec_rx,
  output logic [2:0]        rec_ry,
  output logic [2:0]        rec_ea_mode,
  output logic [IMM_W-1:0]  rec_imm,
  output logic [LEN_W-1:0]  rec_len,
  output logic              rec_illegal
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  op_e              cls_op;
  logic             cls_ill;
  logic [CNT_W-1:0] cls_n;
  imm_kind_e        cls_kind;
  logic [IMM_W-1:0] cls_imm0;
  logic [1:0]       cls_size;

  opdec_classify u_cls (
    .word(in_word), .gen(gen), .op(cls_op), .illegal(cls_ill),
    .n_ext(cls_n), .kind(cls_kind), .imm0(cls_imm0), .size(cls_size)
  );

  dec_state_e       state_q, state_d;
  op_e              op_q;
  logic             ill_q;
  imm_kind_e        kind_q;
  logic [CNT_W-1:0] left_q, left_d;
  logic [WORD_W-1:0] acc_q;
  logic [IMM_W-1:0] imm_q, imm_d, shaped;
  logic [LEN_W-1:0] len_q, len_d;
  logic [1:0]       size_q;
  logic [9:0]       fld_q;
  logic             take_w, load_op, load_ext, load_imm;

  opdec_imm_shape u_shape (
    .kind(kind_q), .hi(acc_q), .lo(in_word), .imm0(imm_q), .imm(shaped)
  );

  assign in_ready = (state_q != ST_OUT);
  assign take_w   = in_valid && in_ready;
  assign load_op  = take_w && (state_q == ST_OP);
  assign load_ext = take_w && (state_q == ST_EXT);

  always_comb begin
    state_d  = state_q;
    left_d   = left_q;
    imm_d    = imm_q;
    len_d    = len_q;
    load_imm = 1'b0;
    unique case (state_q)
      ST_OP: if (load_op) begin
        left_d   = cls_n;
        imm_d    = cls_imm0;
        load_imm = 1'b1;
        len_d    = LEN_W'({cls_n, 1'b0}) + LEN_W'(2);
        state_d  = (cls_n == '0) ? ST_OUT : ST_EXT;
      end
      ST_EXT: if (load_ext) begin
        left_d = left_q - CNT_W'(1);
        if (left_q == CNT_W'(1)) begin
          imm_d    = shaped;
          load_imm = 1'b1;
          state_d  = ST_OUT;
        end
      end
      ST_OUT: if (out_ready) state_d = ST_OP;
      default: state_d = ST_OP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OP;
      left_q  <= '0;
      len_q   <= LEN_W'(2);
      imm_q   <= '0;
      acc_q   <= '0;
      op_q    <= OP_ILL;
      ill_q   <= 1'b0;
      kind_q  <= IK_NONE;
      size_q  <= '0;
      fld_q   <= '0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      len_q   <= len_d;
      if (load_imm) imm_q <= imm_d;
      if (load_ext) acc_q <= in_word;
      if (load_op) begin
        op_q   <= cls_op;
        ill_q  <= cls_ill;
        kind_q <= cls_kind;
        size_q <= cls_size;
        fld_q  <= {in_word[11:8], in_word[5:0]};
      end
    end
  end

  assign out_valid   = (state_q == ST_OUT);
  assign rec_op      = op_q;
  assign rec_illegal = ill_q;
  assign rec_size    = size_q;
  assign rec_cond    = fld_q[9:6];
  assign rec_rx      = fld_q[9:7];
  assign rec_ea_mode = fld_q[5:3];
  assign rec_ry      = fld_q[2:0];
  assign rec_imm     = imm_q;
  assign rec_len     = len_q;

  assert_full_blocks_input_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid |-> !in_ready);
  assert_record_held_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid && !out_ready |=> out_valid && $stable(rec_op) && $stable(rec_imm)
                                 && $stable(rec_len) && $stable(rec_illegal));
  assert_illegal_short_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid && rec_illegal |-> rec_len == LEN_W'(2) && rec_imm == '0);
  assert_len_range_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid |-> !rec_len[0] && rec_len >= LEN_W'(2) && rec_len <= LEN_W'(2 + 2*MAX_EXT));
  assert_valid_after_word_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

// File: tb/tb_opcode_stream_decoder.sv
module tb_opcode_stream_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  gen;
  logic        in_valid, in_ready, out_valid, out_ready, rec_illegal;
  logic [15:0] in_word;
  logic [5:0]  rec_op;
  logic [1:0]  rec_size;
  logic [3:0]  rec_cond;
  logic [2:0]  rec_rx, rec_ry, rec_ea_mode;
  logic [31:0] rec_imm;
  logic [3:0]  rec_len;

  int n_tests = 0;
  int n_fail  = 0;

  int          e_op, e_n;
  logic        e_ill;
  logic [31:0] e_imm;
  logic [1:0]  e_sz;

  always #5 clk = ~clk;

  opcode_stream_decoder dut (
    .clk(clk), .rst_n(rst_n), .gen(gen), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .rec_op(rec_op), .rec_size(rec_size), .rec_cond(rec_cond), .rec_rx(rec_rx),
    .rec_ry(rec_ry), .rec_ea_mode(rec_ea_mode), .rec_imm(rec_imm),
    .rec_len(rec_len), .rec_illegal(rec_illegal)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] sx8(input logic [7:0] v);
    return {{24{v[7]}}, v};
  endfunction
  function automatic logic [31:0] sx16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  // behavioural reference of the requirements
  task automatic ref_decode(input logic [15:0] w0, w1, w2, input logic [1:0] g);
    e_op = 0; e_ill = 0; e_n = 0; e_imm = 0; e_sz = w0[7:6];
    case (w0[15:12])
      4'h0: begin
        if (w0[5:0] == 6'h3C) begin
          if (w0[7:6] == 2'b00 && (w0[11:8] == 0 || w0[11:8] == 2 || w0[11:8] == 4'hA)) begin
            e_op = (w0[11:8] == 0) ? 7 : (w0[11:8] == 2) ? 8 : 9; e_n = 1; e_imm = {24'h0, w1[7:0]};
          end else if (w0[7:6] == 2'b01 && (w0[11:8] == 0 || w0[11:8] == 2 || w0[11:8] == 4'hA)) begin
            e_op = (w0[11:8] == 0) ? 10 : (w0[11:8] == 2) ? 11 : 12; e_n = 1; e_imm = {16'h0, w1};
          end else e_ill = 1;
        end else if (w0[8]) e_op = 13;
        else if (w0[11:8] == 4'h8) begin e_op = 13; e_n = 1; e_imm = {16'h0, w1}; end
        else if (w0[7:6] == 2'b11) e_ill = 1;
        else begin
          case (w0[11:8])
            4'h0: e_op = 1; 4'h2: e_op = 2; 4'h4: e_op = 3;
            4'h6: e_op = 4; 4'hA: e_op = 5; 4'hC: e_op = 6;
            default: e_ill = 1;
          endcase
          if (w0[7:6] == 2'b00) begin e_n = 1; e_imm = {24'h0, w1[7:0]}; end
          else if (w0[7:6] == 2'b01) begin e_n = 1; e_imm = {16'h0, w1}; end
          else begin e_n = 2; e_imm = {w1, w2}; end
        end
      end
      4'h1: begin e_op = 14; e_sz = 2'b00; end
      4'h2: begin e_op = 14; e_sz = 2'b10; end
      4'h3: begin e_op = 14; e_sz = 2'b01; end
      4'h4: begin
        if (w0[11:3] == 9'h1CE) begin
          e_op = 16 + int'(w0[2:0]);
          if (w0[2:0] == 2) begin e_n = 1; e_imm = {16'h0, w1}; end
          if (w0[2:0] == 4) begin
            if (g == 0) e_ill = 1; else begin e_n = 1; e_imm = sx16(w1); end
          end
        end else if (w0[11:4] == 8'hE4) begin e_op = 24; e_imm = {28'h0, w0[3:0]}; end
        else if (w0[11:4] == 8'hE5) begin
          if (w0[3]) e_op = 26; else begin e_op = 25; e_n = 1; e_imm = sx16(w1); end
        end else e_op = 15;
      end
      4'h5: begin
        if (w0[7:6] != 2'b11) begin
          e_op = w0[8] ? 28 : 27; e_imm = (w0[11:9] == 0) ? 8 : {29'h0, w0[11:9]};
        end else if (w0[5:3] == 3'b001) begin e_op = 30; e_n = 1; e_imm = sx16(w1); end
        else e_op = 29;
      end
      4'h6: begin
        e_op = (w0[11:8] == 0) ? 31 : (w0[11:8] == 1) ? 32 : 33;
        if (w0[7:0] == 0) begin e_n = 1; e_imm = sx16(w1); end
        else if (w0[7:0] == 8'hFF && g >= 2) begin e_n = 2; e_imm = {w1, w2}; end
        else e_imm = sx8(w0[7:0]);
      end
      4'h7: if (w0[8]) e_ill = 1; else begin e_op = 34; e_imm = sx8(w0[7:0]); end
      4'h8: e_op = 35;
      4'h9: e_op = 36;
      4'hB: e_op = 37;
      4'hC: e_op = 38;
      4'hD: e_op = 39;
      4'hE: e_op = 40;
      default: e_ill = 1;
    endcase
    if (e_ill) begin e_op = 0; e_n = 0; e_imm = 0; end
  endtask

  task automatic run(input string req, input logic [15:0] w0, w1, w2, input logic [1:0] g,
                     input int hold, input bit gap);
    logic [15:0] ws [0:2];
    ws[0] = w0; ws[1] = w1; ws[2] = w2;
    ref_decode(w0, w1, w2, g);
    gen = g;
    for (int i = 0; i <= e_n; i++) begin
      if (gap && i == 1) begin
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, "in_ready during gap R12", {31'h0, in_ready}, 32'd1);
        @(posedge clk);
      end
      @(negedge clk);
      chk(req, "in_ready while taking R12", {31'h0, in_ready}, 32'd1);
      chk(req, "out_valid early R12", {31'h0, out_valid}, 32'd0);
      in_valid = 1'b1;
      in_word  = ws[i];
      @(posedge clk);
    end
    @(negedge clk);
    in_word = 16'hFFFF;  // offered but must not be taken
    chk(req, "out_valid", {31'h0, out_valid}, 32'd1);
    chk(req, "in_ready while full R3", {31'h0, in_ready}, 32'd0);
    chk(req, "op", {26'h0, rec_op}, e_op);
    chk(req, "illegal", {31'h0, rec_illegal}, {31'h0, e_ill});
    chk(req, "imm", rec_imm, e_imm);
    chk(req, "len R12", {28'h0, rec_len}, 2 + 2 * e_n);
    if (!e_ill) chk(req, "size", {30'h0, rec_size}, {30'h0, e_sz});
    chk(req, "fields R12", {19'h0, rec_cond, rec_rx, rec_ea_mode, rec_ry},
        {19'h0, w0[11:8], w0[11:9], w0[5:3], w0[2:0]});
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk("R3", "held valid", {31'h0, out_valid}, 32'd1);
      chk("R3", "held imm", rec_imm, e_imm);
      chk("R3", "held op", {26'h0, rec_op}, e_op);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b0;
    chk("R3", "released", {31'h0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; gen = 2'd0; in_valid = 1'b0; in_word = 16'h0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3", "reset out_valid", {31'h0, out_valid}, 32'd0);
    chk("R3", "reset in_ready", {31'h0, in_ready}, 32'd1);

    // R1 moves and generic groups
    run("R1", 16'h1234, 0, 0, 0, 0, 0);
    run("R1", 16'h2A48, 0, 0, 0, 0, 0);
    run("R1", 16'h3E01, 0, 0, 0, 2, 0);
    run("R13", 16'hD081, 0, 0, 0, 0, 0);
    run("R13", 16'hE3A8, 0, 0, 0, 0, 0);
    run("R13", 16'h8C40, 0, 0, 0, 0, 0);
    // R2 illegal encodings
    run("R2", 16'hA000, 0, 0, 2, 0, 0);
    run("R2", 16'hF123, 0, 0, 2, 1, 0);
    // R4 / R5 branches
    run("R4", 16'h6000, 16'hFFFE, 0, 0, 0, 0);
    run("R5", 16'h6105, 0, 0, 0, 0, 0);
    run("R4", 16'h67FF, 16'h1111, 0, 0, 0, 0);
    run("R4", 16'h66FF, 16'h1234, 16'h5678, 2, 1, 1);
    run("R4", 16'h6E80, 0, 0, 2, 0, 0);
    run("R5", 16'h6F00, 16'h0100, 0, 3, 0, 1);
    // R6 immediates
    run("R6", 16'h0000, 16'hABCD, 0, 0, 0, 0);
    run("R6", 16'h0641, 16'h8001, 0, 0, 0, 0);
    run("R6", 16'h0C80, 16'hDEAD, 16'hBEEF, 0, 2, 1);
    run("R6", 16'h0E40, 0, 0, 0, 0, 0);
    run("R6", 16'h00C0, 0, 0, 0, 0, 0);
    run("R6", 16'h0A13, 16'h00F0, 0, 0, 0, 0);
    // R7 condition-byte / status-word forms
    run("R7", 16'h003C, 16'h12FF, 0, 0, 0, 0);
    run("R7", 16'h027C, 16'h2700, 0, 0, 0, 0);
    run("R7", 16'h0A3C, 16'h0055, 0, 0, 0, 0);
    run("R7", 16'h043C, 0, 0, 0, 0, 0);
    run("R7", 16'h00BC, 0, 0, 0, 0, 0);
    // R13 bit ops
    run("R13", 16'h0800, 16'h0005, 0, 0, 0, 0);
    run("R13", 16'h0100, 0, 0, 0, 0, 0);
    // R8 quick add/sub, DBcc, Scc
    run("R8", 16'h5048, 0, 0, 0, 0, 0);
    run("R8", 16'h5F80, 0, 0, 0, 0, 0);
    run("R8", 16'h51C9, 16'hFFF0, 0, 0, 0, 0);
    run("R8", 16'h57C0, 0, 0, 0, 0, 0);
    // R9 quick move
    run("R9", 16'h70FF, 0, 0, 0, 0, 0);
    run("R9", 16'h7A10, 0, 0, 0, 0, 0);
    run("R9", 16'h7100, 0, 0, 0, 0, 0);
    // R10 control words
    for (int j = 0; j < 8; j++) run("R10", 16'h4E70 + 16'(j), 16'hFFFC, 0, 1, 0, 0);
    run("R10", 16'h4E74, 16'h0008, 0, 0, 0, 0);
    run("R10", 16'h4E7A, 0, 0, 2, 0, 0);
    run("R10", 16'h4AFC, 0, 0, 0, 0, 0);
    // R11 trap, link, unlink
    run("R11", 16'h4E4F, 0, 0, 0, 0, 0);
    run("R11", 16'h4E56, 16'hFFF8, 0, 0, 0, 1);
    run("R11", 16'h4E5E, 0, 0, 0, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule